// File: doc/BRIEF.md
# Carrier Local Address Space Decoder

This block sits between a host-side local bus and four mezzanine module slots on a carrier card. A host access arrives with a window selector, an address, a width (one or two bytes), a direction and write data. The block decodes the access into a slot number, a module space, an offset and byte enables, and it issues one module strobe. It then returns the read data to the host. Three windows reach the modules. The small 1 KiB window splits each slot into I/O, identification and interrupt spaces. A 32 MiB window gives 16-bit memory access per slot. A 16 MiB window gives byte-only memory access per slot. A fourth selector reaches a byte-wide configuration space. That space holds a fixed pattern of bytes and the three big-endian flags.

When the big-endian flag of a window is set, the block changes the byte lanes. A byte access has address bit 0 inverted. A 16-bit access has its two data bytes swapped for both reads and writes. A slot-present vector gates the strobes. An access to an empty slot never reaches the modules and reads back zero.

A three-state controller sequences each access:
- `ST_IDLE`: waits for a request. `host_req` takes it to `ST_ISSUE` (transition *accept*).
- `ST_ISSUE`: drives the module strobe and captures the response. It always moves on to `ST_RESP` (transition *capture*).
- `ST_RESP`: acknowledges the host for one cycle. It always returns to `ST_IDLE` (transition *retire*).

Top module: `carrier_local_decoder`

## Requirements
- R1: In the 1 KiB window (`host_win`=1), the slot is address bits [9:8] and the space code is bits [7:6]. Code 2 gives the identification space, code 3 gives the interrupt space, and codes 0 and 1 give the I/O space. `mod_space` encodes the spaces as I/O=0, ID=1, INT=2, MEM16=3, MEM8=4.
- R2: In the 1 KiB window, the I/O offset is address bits [6:0] and the ID and INT offsets are bits [5:0]. Both are zero-extended on `mod_offset`.
- R3: In the 32 MiB window (`host_win`=2), the slot is address bits [24:23], the offset is bits [22:0] and `mod_space`=3.
- R4: In the 16 MiB window (`host_win`=3), the slot is address bits [23:22], the offset is bits [21:0] and `mod_space`=4. Every access is a byte access on the low lane (`mod_be`=01, read data taken from `mod_rdata[7:0]`). `host_wide` and the endian flags have no effect in this window.
- R5: Byte lanes in the 1 KiB and 32 MiB windows:
  - A byte access whose effective address bit 0 is 0 uses `mod_be`=01 and the low lane.
  - A byte access whose effective address bit 0 is 1 uses `mod_be`=10 and the high lane.
  - Byte write data is copied onto both lanes. Byte read data comes back in `host_rdata[7:0]` with the upper byte zero.
  - A 16-bit access uses `mod_be`=11.
- R6: When the flag of the window is set, a byte access inverts address bit 0 (in the offset and in the lane choice). A 16-bit access swaps the data bytes of both write and read data. Flag 1 belongs to the 1 KiB window and flag 2 belongs to the 32 MiB window.
- R7: A configuration write (`host_win`=0) to byte offset 0x2B, 0x2F or 0x33 loads flag (offset-0x2B)/4 from write data bit 0. Writes to any other configuration offset change nothing.
- R8: A configuration read of byte offset o (address bits [6:0]) returns the value below in `host_rdata[7:0]`, with the upper byte zero:
  - for o < 88: (o*29+7) mod 256, with the corresponding flag ORed into bit 0 at offsets 0x2B, 0x2F and 0x33;
  - for o ≥ 88: zero.
- R9: An access to a slot whose `slot_present` bit is 0 raises no `mod_stb` and reads back 0. Configuration accesses never raise `mod_stb`.
- R10: A request accepted in `ST_IDLE` raises `mod_stb` for exactly the next cycle. `host_ack` is high for exactly one cycle after that, with `host_rdata` valid in the same cycle. A write acknowledges with zero data.
- R11: After reset, all three flags are 0 (little-endian), and `host_ack` and `mod_stb` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Access request, sampled in idle |
| host_win | input | 2 | Window: 0 config, 1 I/O-ID-INT, 2 MEM16, 3 MEM8 |
| host_we | input | 1 | 1 = write |
| host_wide | input | 1 | 1 = 16-bit access, 0 = byte |
| host_addr | input | 25 | Byte address within the window |
| host_wdata | input | 16 | Write data (byte accesses use [7:0]) |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 16 | Read data, valid with host_ack |
| slot_present | input | 4 | Per-slot module installed flag |
| mod_stb | output | 1 | Module access strobe |
| mod_we | output | 1 | Module write |
| mod_slot | output | 2 | Target slot |
| mod_space | output | 3 | Target space code |
| mod_offset | output | 23 | Offset within the space |
| mod_be | output | 2 | Byte lane enables |
| mod_wdata | output | 16 | Lane-steered write data |
| mod_rdata | input | 16 | Module read data, sampled during the strobe |

## Verification
The bench sweeps every slot and space code of the 1 KiB window at offsets where bit 6 or bit 0 matters. It runs each sweep with both widths, both directions and both flag values. A decoder that masks the I/O offset to six bits, or that treats space code 1 as a separate space, fails there. A design that flips the address on 16-bit accesses, or swaps bytes on byte accesses, sends the wrong lane enables and wrong data. The bench also writes wide data and sets the flags in the 16 MiB window. A design that honours width or endianness there gives a non-low lane. The bench reads the whole configuration space before and after writes to offsets next to the flag bytes. A stray write decode shows up as a changed flag. An empty slot is checked for a strobe that leaks through or for non-zero read data.

// File: rtl/carrier_dec_pkg.sv
package carrier_dec_pkg;

    localparam int NSLOT        = 4;
    localparam int SLOT_W       = $clog2(NSLOT);
    localparam int HADDR_W      = 25;
    localparam int DATA_W       = 16;
    localparam int BYTE_W       = 8;
    localparam int NLANE        = DATA_W / BYTE_W;
    localparam int OFS_W        = 23;

    localparam int IO_SLOT_LSB  = 8;
    localparam int IO_CODE_LSB  = 6;
    localparam int IO_OFS_W     = 7;
    localparam int IDINT_OFS_W  = 6;
    localparam int M16_OFS_W    = 23;
    localparam int M8_OFS_W     = 22;

    localparam int CFG_OFS_W    = 7;
    localparam int CFG_DEPTH    = 88;
    localparam int CFG_MUL      = 29;
    localparam int CFG_ADD      = 7;
    localparam int NFLAG        = 3;
    localparam int FLAG_BASE    = 'h2B;
    localparam int FLAG_STEP    = 4;

    typedef enum logic [1:0] {
        WIN_CFG   = 2'd0,
        WIN_IOID  = 2'd1,
        WIN_MEM16 = 2'd2,
        WIN_MEM8  = 2'd3
    } win_e;

    typedef enum logic [2:0] {
        SP_IO    = 3'd0,
        SP_ID    = 3'd1,
        SP_INT   = 3'd2,
        SP_MEM16 = 3'd3,
        SP_MEM8  = 3'd4
    } space_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_RESP  = 2'd2
    } state_e;

    typedef struct packed {
        logic [SLOT_W-1:0] slot;
        space_e            space;
        logic [OFS_W-1:0]  ofs;
        logic [NLANE-1:0]  be;
        logic              byte_acc;
        logic              hi_lane;
        logic              swap;
        logic              is_cfg;
    } dec_t;

endpackage

// File: rtl/carrier_cfg_space.sv
module carrier_cfg_space
    import carrier_dec_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [CFG_OFS_W-1:0] ofs,
    input  logic [BYTE_W-1:0]    wdata,
    output logic [NFLAG-1:0]     flags,
    output logic [BYTE_W-1:0]    rdata
);

    logic [BYTE_W-1:0] pattern;

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        localparam int FOFS = FLAG_BASE + g * FLAG_STEP;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flags[g] <= 1'b0;
            else if (wr_en && (int'(ofs) == FOFS))
                flags[g] <= wdata[0];
        end
    end

    always_comb begin
        if (int'(ofs) < CFG_DEPTH)
            pattern = BYTE_W'(int'(ofs) * CFG_MUL + CFG_ADD);
        else
            pattern = '0;
        rdata = pattern;
        for (int k = 0; k < NFLAG; k++) begin
            if (int'(ofs) == FLAG_BASE + k * FLAG_STEP)
                rdata[0] = pattern[0] | flags[k];
        end
    end

    // flags move only on a configuration write
    p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(flags));

endmodule

// File: rtl/carrier_addr_decode.sv
module carrier_addr_decode
    import carrier_dec_pkg::*;
(
    input  win_e               win,
    input  logic               wide,
    input  logic [HADDR_W-1:0] addr,
    input  logic               big_io,
    input  logic               big_m16,
    output dec_t               dec
);

    logic               bigf;
    logic               byte_acc;
    logic [HADDR_W-1:0] a;
    logic [1:0]         code;

    always_comb begin
        byte_acc = (win == WIN_MEM8) || (win == WIN_CFG) || !wide;
        bigf     = (win == WIN_IOID) ? big_io : (win == WIN_MEM16) ? big_m16 : 1'b0;
        a        = addr ^ HADDR_W'(byte_acc && bigf);
        code     = a[IO_CODE_LSB +: 2];

        dec          = '0;
        dec.byte_acc = byte_acc;
        dec.swap     = !byte_acc && bigf;
        dec.hi_lane  = byte_acc && (win != WIN_MEM8) && a[0];
        if (win == WIN_MEM8 || win == WIN_CFG)
            dec.be = 2'b01;
        else if (!byte_acc)
            dec.be = 2'b11;
        else
            dec.be = a[0] ? 2'b10 : 2'b01;

        unique case (win)
            WIN_CFG: begin
                dec.is_cfg = 1'b1;
                dec.space  = SP_IO;
                dec.ofs    = OFS_W'(a[CFG_OFS_W-1:0]);
            end
            WIN_IOID: begin
                dec.slot = a[IO_SLOT_LSB +: SLOT_W];
                case (code)
                    2'd2: begin
                        dec.space = SP_ID;
                        dec.ofs   = OFS_W'(a[IDINT_OFS_W-1:0]);
                    end
                    2'd3: begin
                        dec.space = SP_INT;
                        dec.ofs   = OFS_W'(a[IDINT_OFS_W-1:0]);
                    end
                    default: begin
                        dec.space = SP_IO;
                        dec.ofs   = OFS_W'(a[IO_OFS_W-1:0]);
                    end
                endcase
            end
            WIN_MEM16: begin
                dec.slot  = a[M16_OFS_W +: SLOT_W];
                dec.space = SP_MEM16;
                dec.ofs   = OFS_W'(a[M16_OFS_W-1:0]);
            end
            WIN_MEM8: begin
                dec.slot  = a[M8_OFS_W +: SLOT_W];
                dec.space = SP_MEM8;
                dec.ofs   = OFS_W'(a[M8_OFS_W-1:0]);
            end
        endcase
    end

endmodule

// File: rtl/carrier_lane_steer.sv
module carrier_lane_steer
    import carrier_dec_pkg::*;
(
    input  logic              byte_acc,
    input  logic              hi_lane,
    input  logic              swap,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [DATA_W-1:0] mod_rdata,
    output logic [DATA_W-1:0] mod_wdata,
    output logic [DATA_W-1:0] host_rdata
);

    always_comb begin
        if (byte_acc) begin
            mod_wdata  = {host_wdata[BYTE_W-1:0], host_wdata[BYTE_W-1:0]};
            host_rdata = {{BYTE_W{1'b0}},
                          hi_lane ? mod_rdata[DATA_W-1:BYTE_W] : mod_rdata[BYTE_W-1:0]};
        end else if (swap) begin
            mod_wdata  = {host_wdata[BYTE_W-1:0], host_wdata[DATA_W-1:BYTE_W]};
            host_rdata = {mod_rdata[BYTE_W-1:0], mod_rdata[DATA_W-1:BYTE_W]};
        end else begin
            mod_wdata  = host_wdata;
            host_rdata = mod_rdata;
        end
    end

endmodule

// File: rtl/carrier_local_decoder.sv
module carrier_local_decoder
    import carrier_dec_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_req,
    input  logic [1:0]           host_win,
    input  logic                 host_we,
    input  logic                 host_wide,
    input  logic [HADDR_W-1:0]   host_addr,
    input  logic [DATA_W-1:0]    host_wdata,
    output logic                 host_ack,
    output logic [DATA_W-1:0]    host_rdata,
    input  logic [NSLOT-1:0]     slot_present,
    output logic                 mod_stb,
    output logic                 mod_we,
    output logic [SLOT_W-1:0]    mod_slot,
    output logic [2:0]           mod_space,
    output logic [OFS_W-1:0]     mod_offset,
    output logic [NLANE-1:0]     mod_be,
    output logic [DATA_W-1:0]    mod_wdata,
    input  logic [DATA_W-1:0]    mod_rdata
);

    state_e              state, state_nx;
    dec_t                dec_in, req_q;
    logic                we_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [DATA_W-1:0]   rdata_q, rdata_nx;
    logic [DATA_W-1:0]   lane_rd;
    logic [NFLAG-1:0]    flags;
    logic [BYTE_W-1:0]   cfg_rd;
    logic                cfg_wr;
    logic                hit;

    carrier_addr_decode u_dec (
        .win     (win_e'(host_win)),
        .wide    (host_wide),
        .addr    (host_addr),
        .big_io  (flags[1]),
        .big_m16 (flags[2]),
        .dec     (dec_in)
    );

    carrier_cfg_space u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_wr),
        .ofs   (req_q.ofs[CFG_OFS_W-1:0]),
        .wdata (wdata_q[BYTE_W-1:0]),
        .flags (flags),
        .rdata (cfg_rd)
    );

    carrier_lane_steer u_lane (
        .byte_acc   (req_q.byte_acc),
        .hi_lane    (req_q.hi_lane),
        .swap       (req_q.swap),
        .host_wdata (wdata_q),
        .mod_rdata  (mod_rdata),
        .mod_wdata  (mod_wdata),
        .host_rdata (lane_rd)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state: accept / capture / retire
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (host_req) state_nx = ST_ISSUE;
            ST_ISSUE: state_nx = ST_RESP;
            ST_RESP:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        hit      = !req_q.is_cfg && slot_present[req_q.slot];
        mod_stb  = 1'b0;
        host_ack = 1'b0;
        cfg_wr   = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_ISSUE: begin
                mod_stb = hit;
                cfg_wr  = req_q.is_cfg && we_q;
            end
            ST_RESP:  host_ack = 1'b1;
            default:  ;
        endcase
        mod_we     = we_q;
        mod_slot   = req_q.slot;
        mod_space  = req_q.space;
        mod_offset = req_q.ofs;
        mod_be     = req_q.be;
        host_rdata = rdata_q;
    end

    always_comb begin
        if (we_q)
            rdata_nx = '0;
        else if (req_q.is_cfg)
            rdata_nx = DATA_W'(cfg_rd);
        else if (hit)
            rdata_nx = lane_rd;
        else
            rdata_nx = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q   <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (state == ST_IDLE && host_req) begin
                req_q   <= dec_in;
                we_q    <= host_we;
                wdata_q <= host_wdata;
            end
            if (state == ST_ISSUE)
                rdata_q <= rdata_nx;
        end
    end

    p_stb_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mod_stb |=> !mod_stb);
    p_stb_then_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mod_stb |=> host_ack);
    p_ack_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);
    p_present_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mod_stb |-> slot_present[mod_slot]);
    p_mem8_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_stb && mod_space == SP_MEM8) |-> (mod_be == 2'b01 && mod_offset[OFS_W-1] == 1'b0));
    p_idint_ofs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_stb && (mod_space == SP_ID || mod_space == SP_INT)) |-> mod_offset[OFS_W-1:IDINT_OFS_W] == '0);
    p_be_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mod_stb |-> mod_be != 2'b00);

endmodule

// File: tb/carrier_local_decoder_test.sv
module carrier_local_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic [1:0]  host_win = 2'd0;
    logic        host_we = 1'b0;
    logic        host_wide = 1'b0;
    logic [24:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic        host_ack;
    logic [15:0] host_rdata;
    logic [3:0]  slot_present = 4'hF;
    logic        mod_stb, mod_we;
    logic [1:0]  mod_slot;
    logic [2:0]  mod_space;
    logic [22:0] mod_offset;
    logic [1:0]  mod_be;
    logic [15:0] mod_wdata;
    logic [15:0] mod_rdata;

    int n_run = 0;
    int n_fail = 0;
    logic [2:0] ef = 3'b000;

    always #10 clk = ~clk;

    carrier_local_decoder uut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_win(host_win),
        .host_we(host_we), .host_wide(host_wide), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_ack(host_ack), .host_rdata(host_rdata),
        .slot_present(slot_present), .mod_stb(mod_stb), .mod_we(mod_we),
        .mod_slot(mod_slot), .mod_space(mod_space), .mod_offset(mod_offset),
        .mod_be(mod_be), .mod_wdata(mod_wdata), .mod_rdata(mod_rdata)
    );

    function automatic logic [15:0] stub(logic [1:0] s, logic [22:0] o);
        return o[15:0] ^ {2'b00, s, 12'hA5C};
    endfunction

    always_comb mod_rdata = stub(mod_slot, mod_offset);

    task automatic chk(string tag, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic int cfg_exp(int o);
        int v;
        v = (o < 88) ? ((o * 29 + 7) % 256) : 0;
        if (o == 'h2B) v = v | int'(ef[0]);
        if (o == 'h2F) v = v | int'(ef[1]);
        if (o == 'h33) v = v | int'(ef[2]);
        return v;
    endfunction

    task automatic access(input int win, input bit we, input bit wide,
                          input logic [24:0] addr, input logic [15:0] wd);
        bit          byte_acc, bigf, pres;
        logic [24:0] a;
        int          slot, space, ofs, be, exp_rd;
        logic [15:0] r, ew;
        string       tg;
        byte_acc = (win == 3) || (win == 0) || !wide;
        bigf     = (win == 1) ? ef[1] : (win == 2) ? ef[2] : 1'b0;
        a        = addr ^ 25'(byte_acc && bigf);
        slot = 0; space = 0; ofs = 0;
        if (win == 1) begin
            slot = int'(a[9:8]);
            if (a[7:6] == 2'd2)      begin space = 1; ofs = int'(a[5:0]); end
            else if (a[7:6] == 2'd3) begin space = 2; ofs = int'(a[5:0]); end
            else                     begin space = 0; ofs = int'(a[6:0]); end
            tg = "R1";
        end else if (win == 2) begin
            slot = int'(a[24:23]); space = 3; ofs = int'(a[22:0]); tg = "R3";
        end else begin
            slot = int'(a[23:22]); space = 4; ofs = int'(a[21:0]); tg = "R4";
        end
        be = (win == 3) ? 1 : !byte_acc ? 3 : a[0] ? 2 : 1;
        ew = byte_acc ? {wd[7:0], wd[7:0]} : bigf ? {wd[7:0], wd[15:8]} : wd;
        pres = (win != 0) && slot_present[slot];

        @(negedge clk);
        host_req = 1'b1; host_win = 2'(win); host_we = we; host_wide = wide;
        host_addr = addr; host_wdata = wd;
        @(negedge clk);
        host_req = 1'b0;
        if (win == 0) begin
            chk("R9 cfg no strobe", int'(mod_stb), 0);
        end else if (!pres) begin
            chk("R9 absent no strobe", int'(mod_stb), 0);
        end else begin
            chk("R10 strobe", int'(mod_stb), 1);
            chk({tg, " slot"}, int'(mod_slot), slot);
            chk({tg, " space"}, int'(mod_space), space);
            chk((win == 1) ? "R2 offset" : {tg, " offset"}, int'(mod_offset), ofs);
            chk((win == 3) ? "R4 lane" : (bigf ? "R6 be" : "R5 be"), int'(mod_be), be);
            chk("R10 we", int'(mod_we), int'(we));
            if (we) chk(bigf ? "R6 wdata" : "R5 wdata", int'(mod_wdata), int'(ew));
        end
        chk("R10 no early ack", int'(host_ack), 0);
        @(negedge clk);
        chk("R10 ack", int'(host_ack), 1);
        if (win == 0) begin
            exp_rd = we ? 0 : cfg_exp(int'(addr[6:0]));
            chk("R8 cfg read", int'(host_rdata), exp_rd);
            if (we) begin
                if (addr[6:0] == 7'h2B) ef[0] = wd[0];
                if (addr[6:0] == 7'h2F) ef[1] = wd[0];
                if (addr[6:0] == 7'h33) ef[2] = wd[0];
            end
        end else begin
            r = stub(2'(slot), 23'(ofs));
            if (!pres || we) exp_rd = 0;
            else if (win == 3) exp_rd = int'(r[7:0]);
            else if (byte_acc) exp_rd = a[0] ? int'(r[15:8]) : int'(r[7:0]);
            else exp_rd = bigf ? int'({r[7:0], r[15:8]}) : int'(r);
            chk(!pres ? "R9 absent read" : (bigf ? "R6 rdata" : "R5 rdata"),
                int'(host_rdata), exp_rd);
        end
        @(negedge clk);
        chk("R10 ack one cycle", int'(host_ack), 0);
    endtask

    task automatic cfg_sweep();
        for (int o = 0; o < 128; o++) access(0, 1'b0, 1'b0, 25'(o), 16'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 ack in reset", int'(host_ack), 0);
        chk("R11 stb in reset", int'(mod_stb), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 ack after reset", int'(host_ack), 0);
        chk("R11 stb after reset", int'(mod_stb), 0);

        // R11 / R8: flags read back as zero, full pattern
        cfg_sweep();

        // R1 R2 R5 R6 R9: 1 KiB window sweep, slot 2 absent
        slot_present = 4'b1011;
        for (int f = 0; f < 2; f++) begin
            access(0, 1'b1, 1'b0, 25'h2F, 16'(f));
            for (int s = 0; s < 4; s++)
                for (int c = 0; c < 4; c++)
                    for (int k = 0; k < 4; k++)
                        for (int w = 0; w < 2; w++)
                            for (int d = 0; d < 2; d++) begin
                                int lo;
                                lo = (k == 0) ? 0 : (k == 1) ? 1 : (k == 2) ? 'h2A : 'h3F;
                                access(1, d[0], w[0], 25'(s * 256 + c * 64 + lo),
                                       16'(16'hC3A5 ^ (s * 4 + k)));
                            end
        end

        // R3 R5 R6: 32 MiB window
        slot_present = 4'b1101;
        for (int f = 0; f < 2; f++) begin
            access(0, 1'b1, 1'b0, 25'h33, 16'(f));
            for (int s = 0; s < 4; s++)
                for (int k = 0; k < 3; k++)
                    for (int w = 0; w < 2; w++)
                        for (int d = 0; d < 2; d++) begin
                            int lo;
                            lo = (k == 0) ? 'h0 : (k == 1) ? 'h7F_FFFF : 'h41_2345;
                            access(2, d[0], w[0], 25'(s * 'h80_0000 + lo), 16'h9D17);
                        end
        end

        // R4: 16 MiB window, flags set, wide requested, bit 24 set
        slot_present = 4'hF;
        access(0, 1'b1, 1'b0, 25'h2F, 16'h0001);
        for (int s = 0; s < 4; s++)
            for (int k = 0; k < 3; k++)
                for (int w = 0; w < 2; w++)
                    for (int d = 0; d < 2; d++) begin
                        int lo;
                        lo = (k == 0) ? 'h1 : (k == 1) ? 'h3F_FFFF : 'h12_3456;
                        access(3, d[0], w[0], 25'((k == 2 ? 'h100_0000 : 0) + s * 'h40_0000 + lo),
                               16'h6E2B);
                    end

        // R7: writes near the flags and elsewhere are ignored; bit 0 only loads
        access(0, 1'b1, 1'b0, 25'h2B, 16'h00FF);
        access(0, 1'b1, 1'b0, 25'h33, 16'h00FE);
        access(0, 1'b1, 1'b0, 25'h2A, 16'h00FE);
        access(0, 1'b1, 1'b0, 25'h2C, 16'h00FE);
        access(0, 1'b1, 1'b0, 25'h2E, 16'h00FE);
        access(0, 1'b1, 1'b0, 25'h00, 16'h00FF);
        access(0, 1'b1, 1'b0, 25'h7F, 16'h00FF);
        chk("R7 flags model", int'(ef), 3);
        cfg_sweep();

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule